// File: doc/BRIEF.md
# Descending Hardware Stack Sequencer

This block owns the stack pointer of a small processor core and turns one stack command into the right series of single-byte memory accesses on a fixed 256-byte stack page. The commands are a byte push, a word push, a byte pop and a word pop. There are also four compound operations: saving the return address and status on interrupt entry, restoring them on interrupt return, pushing a return address for a subroutine call, and popping it again on subroutine return. The stack grows downward. A push writes the byte at the slot the pointer names and then moves the pointer down. A pop first moves the pointer up and reads the byte there.

The surrounding core presents a command with its data and waits while `busy` is high. The block makes exactly one memory access per clock on a write/read port to a synchronous RAM, and that RAM returns read data one cycle after the request. When the sequence ends, the block raises `done` for one cycle with the assembled result. A pop that would pass the top of the page is refused. The refusal is reported with `underflow` alongside `done`.

Top module: `dstk_seq`

## Requirements
- R1: Byte push (cmd_op 3'd0) writes cmd_word[7:0] to address 0x0100 + SP and then lowers SP by one.
- R2: Word push (cmd_op 3'd1) writes cmd_word[15:8] at 0x0100 + SP, then cmd_word[7:0] at the next lower address, and lowers SP by two.
- R3: Byte pop (cmd_op 3'd2) raises SP by one and reads address 0x0100 + the new SP. At done, res_word is that byte zero-extended to 16 bits.
- R4: Word pop (cmd_op 3'd3) reads the low byte first and the high byte second, at rising addresses. At done, res_word = low | (high << 8).
- R5: When a pop step finds SP at 0xFF, that step makes no read and leaves SP at 0xFF. Any later steps are abandoned, and done comes with underflow = 1. Bytes already popped in the same command keep their effect.
- R6: Context push (cmd_op 3'd4) writes cmd_word[15:8], then cmd_word[7:0], then cmd_status, one per cycle at falling addresses, and lowers SP by three.
- R7: Interrupt return (cmd_op 3'd5) pops the status byte first and then a word, low byte before high. At done, res_status holds the status and res_word holds the word.
- R8: Subroutine return (cmd_op 3'd6) pops a word and gives res_word = word + 1, wrapping modulo 2^16, so 0xFFFF returns 0x0000.
- R9: Subroutine call (cmd_op 3'd7) pushes cmd_word as a word, high byte first. At done, res_word equals cmd_target.
- R10: A command is taken only when cmd_valid is high and busy is low. Each access takes one cycle, with never a read and a write together. Done rises N+1 clock edges after the accepting edge, where N is the number of cycles spent on steps (an abandoned step counts as one). A command presented while busy is ignored.
- R11: After reset, SP = 0xFF, busy = 0, done = 0, underflow = 0, and neither memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_word | input | 16 | Byte (low bits), word or return address to push |
| cmd_status | input | 8 | Status byte for context push |
| cmd_target | input | 16 | Jump target returned by a call |
| busy | output | 1 | Sequence in progress; commands ignored |
| done | output | 1 | One-cycle end-of-command strobe |
| underflow | output | 1 | With done: a pop was refused at the top of the page |
| res_word | output | 16 | Popped word or byte, return address or call target |
| res_status | output | 8 | Status byte popped by interrupt return |
| sp | output | 8 | Current stack pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |

## Verification
Pushes and pops are paired so that every value read back was written by a different command kind. A word pushed and then popped as a word shows whether the byte order is swapped on either side. A context push followed by an interrupt return separates status-first from status-last ordering. Calls with return addresses 0x1233 and 0xFFFF test the increment and its wrap. Pops at pointer 0xFF, both at the first byte and midway through a word, tell an immediate refusal apart from a partial one. A command held during a busy push shows whether a second sequence could start.

// File: rtl/dstk_pkg.sv
// Shared types for the stack sequencer: command codes and access kinds.
package dstk_pkg;

    // Command codes presented on cmd_op.
    typedef enum logic [2:0] {
        OP_PUSH_B   = 3'd0,
        OP_PUSH_W   = 3'd1,
        OP_POP_B    = 3'd2,
        OP_POP_W    = 3'd3,
        OP_PUSH_CTX = 3'd4,
        OP_RET_INT  = 3'd5,
        OP_RET_SUB  = 3'd6,
        OP_CALL     = 3'd7
    } op_e;

    // Kind of one single-byte memory access inside a sequence.
    typedef enum logic [2:0] {
        AK_WR_HI = 3'd0,
        AK_WR_LO = 3'd1,
        AK_WR_ST = 3'd2,
        AK_RD_LO = 3'd3,
        AK_RD_HI = 3'd4,
        AK_RD_ST = 3'd5,
        AK_NONE  = 3'd6
    } acc_e;

    // One step of a sequence: what to do and whether it ends the command.
    typedef struct packed {
        acc_e kind;
        logic last;
    } step_t;

    // True for access kinds that read memory.
    function automatic logic acc_is_read(acc_e k);
        return (k == AK_RD_LO) || (k == AK_RD_HI) || (k == AK_RD_ST);
    endfunction

    // True for access kinds that write memory.
    function automatic logic acc_is_write(acc_e k);
        return (k == AK_WR_HI) || (k == AK_WR_LO) || (k == AK_WR_ST);
    endfunction

endpackage

// File: rtl/dstk_plan.sv
// Step planner: maps a command and a step index to the access made in that step.
// Assumes the sequencer never advances past a step marked last.
module dstk_plan
    import dstk_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  op_e               op,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    // Sequence table: order here is the stack byte order of each command.
    always_comb begin
        step = '{kind: AK_NONE, last: 1'b1};
        unique case (op)
            OP_PUSH_B: begin
                if (idx == STEP_W'(0)) step = '{kind: AK_WR_LO, last: 1'b1};
            end
            OP_PUSH_W, OP_CALL: begin
                if (idx == STEP_W'(0))      step = '{kind: AK_WR_HI, last: 1'b0};
                else if (idx == STEP_W'(1)) step = '{kind: AK_WR_LO, last: 1'b1};
            end
            OP_POP_B: begin
                if (idx == STEP_W'(0)) step = '{kind: AK_RD_LO, last: 1'b1};
            end
            OP_POP_W, OP_RET_SUB: begin
                if (idx == STEP_W'(0))      step = '{kind: AK_RD_LO, last: 1'b0};
                else if (idx == STEP_W'(1)) step = '{kind: AK_RD_HI, last: 1'b1};
            end
            OP_PUSH_CTX: begin
                if (idx == STEP_W'(0))      step = '{kind: AK_WR_HI, last: 1'b0};
                else if (idx == STEP_W'(1)) step = '{kind: AK_WR_LO, last: 1'b0};
                else if (idx == STEP_W'(2)) step = '{kind: AK_WR_ST, last: 1'b1};
            end
            OP_RET_INT: begin
                if (idx == STEP_W'(0))      step = '{kind: AK_RD_ST, last: 1'b0};
                else if (idx == STEP_W'(1)) step = '{kind: AK_RD_LO, last: 1'b0};
                else if (idx == STEP_W'(2)) step = '{kind: AK_RD_HI, last: 1'b1};
            end
            default: step = '{kind: AK_NONE, last: 1'b1};
        endcase
    end

endmodule

// File: rtl/dstk_ptr.sv
// Stack pointer: holds SP, gives the push slot and pop slot addresses in the page.
// Assumes push and pop are never requested together.
module dstk_ptr #(
    parameter int              SP_W      = 8,
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   PAGE_BASE = 16'h0100,
    parameter logic [SP_W-1:0] INIT_SP   = 8'hFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_push,
    input  logic            do_pop,
    output logic [SP_W-1:0] sp,
    output logic [AW-1:0]   push_addr,
    output logic [AW-1:0]   pop_addr,
    output logic            at_top
);

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_up;

    // Pointer one slot above the current one, wrapping inside the page.
    assign sp_up     = sp_q + SP_W'(1);
    assign sp        = sp_q;
    assign push_addr = PAGE_BASE + AW'(sp_q);
    assign pop_addr  = PAGE_BASE + AW'(sp_up);
    assign at_top    = (sp_q == {SP_W{1'b1}});

    // Pointer update: down after a push, up after a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)       sp_q <= INIT_SP;
        else if (do_push) sp_q <= sp_q - SP_W'(1);
        else if (do_pop)  sp_q <= sp_up;
    end

    AST_PTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> sp_q == $past(sp_q) - SP_W'(1)); // R1
    AST_PTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |=> sp_q == $past(sp_q) + SP_W'(1)); // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_push && !do_pop) |=> $stable(sp_q)); // R5
    AST_PTR_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_push && do_pop)); // R10

endmodule

// File: rtl/dstk_gather.sv
// Result gatherer: captures read data one cycle after each read into the slot its kind names.
// Assumes the memory returns data exactly one cycle after the read strobe.
module dstk_gather
    import dstk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rd_issue,
    input  acc_e          rd_kind,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] hi,
    output logic [DW-1:0] st
);

    acc_e pend_q;

    // Remember which slot the read issued this cycle will fill.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= AK_NONE;
        else if (rd_issue) pend_q <= rd_kind;
        else               pend_q <= AK_NONE;
    end

    // Slot capture: clear on a new command, fill as read data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lo <= '0;
            hi <= '0;
            st <= '0;
        end else begin
            if (pend_q == AK_RD_LO) lo <= rdata;
            if (pend_q == AK_RD_HI) hi <= rdata;
            if (pend_q == AK_RD_ST) st <= rdata;
        end
    end

    AST_GATHER_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> acc_is_read(rd_kind)); // R4

endmodule

// File: rtl/dstk_seq.sv
// Stack sequencer top: accepts one stack command, runs its byte accesses one per
// clock, then strobes done with the result. Assumes a synchronous RAM on the
// memory port with one cycle of read latency and a fixed 256-byte stack page.
module dstk_seq
    import dstk_pkg::*;
#(
    parameter int              DW        = 8,
    parameter int              AW        = 16,
    parameter int              SP_W      = 8,
    parameter logic [AW-1:0]   PAGE_BASE = 16'h0100,
    parameter logic [SP_W-1:0] INIT_SP   = 8'hFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [2*DW-1:0] cmd_word,
    input  logic [DW-1:0]   cmd_status,
    input  logic [2*DW-1:0] cmd_target,
    output logic            busy,
    output logic            done,
    output logic            underflow,
    output logic [2*DW-1:0] res_word,
    output logic [DW-1:0]   res_status,
    output logic [SP_W-1:0] sp,
    output logic            mem_we,
    output logic            mem_re,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);

    localparam int WW     = 2 * DW;
    localparam int STEP_W = 2;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

    state_e            state_q;
    op_e               op_q;
    logic [WW-1:0]     word_q;
    logic [DW-1:0]     stat_q;
    logic [WW-1:0]     tgt_q;
    logic [STEP_W-1:0] idx_q;
    logic              err_q;
    logic              done_q;

    step_t             cur;
    logic              running;
    logic              is_rd;
    logic              is_wr;
    logic              refuse;
    logic              accept;
    logic [AW-1:0]     push_addr;
    logic [AW-1:0]     pop_addr;
    logic              at_top;
    logic [DW-1:0]     slot_lo;
    logic [DW-1:0]     slot_hi;
    logic [DW-1:0]     slot_st;
    logic [WW-1:0]     popped;

    dstk_plan #(.STEP_W(STEP_W)) u_plan (
        .op   (op_q),
        .idx  (idx_q),
        .step (cur)
    );

    // Decode the access of the current step and whether it must be refused.
    assign running = (state_q == S_RUN);
    assign is_rd   = running && acc_is_read(cur.kind);
    assign is_wr   = running && acc_is_write(cur.kind);
    assign refuse  = is_rd && at_top;
    assign accept  = (state_q == S_IDLE) && cmd_valid;

    dstk_ptr #(
        .SP_W      (SP_W),
        .AW        (AW),
        .PAGE_BASE (PAGE_BASE),
        .INIT_SP   (INIT_SP)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_push   (is_wr),
        .do_pop    (is_rd && !at_top),
        .sp        (sp),
        .push_addr (push_addr),
        .pop_addr  (pop_addr),
        .at_top    (at_top)
    );

    dstk_gather #(.DW(DW)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .rd_issue (mem_re),
        .rd_kind  (cur.kind),
        .rdata    (mem_rdata),
        .lo       (slot_lo),
        .hi       (slot_hi),
        .st       (slot_st)
    );

    // Memory port drive: one access per running step.
    assign mem_we   = is_wr;
    assign mem_re   = is_rd && !at_top;
    assign mem_addr = is_wr ? push_addr : pop_addr;

    // Write data selection by access kind.
    always_comb begin
        unique case (cur.kind)
            AK_WR_HI: mem_wdata = word_q[WW-1:DW];
            AK_WR_ST: mem_wdata = stat_q;
            default:  mem_wdata = word_q[DW-1:0];
        endcase
    end

    // Command sequencing: accept, step through accesses, drain last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_PUSH_B;
            word_q  <= '0;
            stat_q  <= '0;
            tgt_q   <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= op_e'(cmd_op);
                        word_q  <= cmd_word;
                        stat_q  <= cmd_status;
                        tgt_q   <= cmd_target;
                        idx_q   <= '0;
                        err_q   <= 1'b0;
                        state_q <= S_RUN;
                    end
                end
                S_RUN: begin
                    if (refuse) begin
                        err_q   <= 1'b1;
                        state_q <= S_FIN;
                    end else if (cur.last) begin
                        state_q <= S_FIN;
                    end else begin
                        idx_q <= idx_q + STEP_W'(1);
                    end
                end
                S_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Result formation from the gathered slots and the command kind.
    assign popped = {slot_hi, slot_lo};
    always_comb begin
        unique case (op_q)
            OP_RET_SUB: res_word = popped + WW'(1);
            OP_CALL:    res_word = tgt_q;
            default:    res_word = popped;
        endcase
    end

    assign res_status = slot_st;
    assign busy       = (state_q != S_IDLE);
    assign done       = done_q;
    assign underflow  = done_q && err_q;

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R10
    AST_NO_POP_PAST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> sp != {SP_W{1'b1}}); // R5
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_UNDERFLOW_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> done); // R5

endmodule

// File: tb/dstk_seq_test.sv
`timescale 1ns/1ps
// Directed bench for the stack sequencer: one task per scenario, RAM model inside.
module dstk_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_word = 16'h0;
    logic [7:0]  cmd_status = 8'h0;
    logic [15:0] cmd_target = 16'h0;
    logic        busy, done, underflow;
    logic [15:0] res_word;
    logic [7:0]  res_status, sp;
    logic        mem_we, mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;

    int nvec = 0;
    int nbad = 0;
    bit finished = 0;

    // Memory model and access logs
    logic [7:0]  mem [0:255];
    logic [15:0] wa [0:255];
    logic [7:0]  wd [0:255];
    logic [15:0] ra [0:255];
    logic [7:0]  wn = 8'd0;
    logic [7:0]  rn = 8'd0;
    logic [7:0]  w0, r0;
    int          cyc;

    always #2.5 clk = ~clk;

    dstk_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .cmd_status(cmd_status), .cmd_target(cmd_target),
        .busy(busy), .done(done), .underflow(underflow), .res_word(res_word),
        .res_status(res_status), .sp(sp), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wa[wn] <= mem_addr;
            wd[wn] <= mem_wdata;
            wn <= wn + 8'd1;
        end
        if (mem_re) begin
            mem_rdata <= mem[mem_addr[7:0]];
            ra[rn] <= mem_addr;
            rn <= rn + 8'd1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one command and wait for done; cyc counts edges after acceptance.
    task automatic run_cmd(input logic [2:0] op, input logic [15:0] w,
                           input logic [7:0] st, input logic [15:0] tg);
        @(negedge clk);
        w0 = wn; r0 = rn;
        cmd_valid = 1'b1; cmd_op = op; cmd_word = w; cmd_status = st; cmd_target = tg;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 50) begin
            @(posedge clk); #1;
            cyc++;
        end
    endtask

    task automatic t_reset();
        chk("R11", "sp", sp, 8'hFF);
        chk("R11", "busy", busy, 0);
        chk("R11", "done", done, 0);
        chk("R11", "underflow", underflow, 0);
        chk("R11", "strobes", {mem_we, mem_re}, 0);
    endtask

    task automatic t_push_byte();
        run_cmd(3'd0, 16'h00A5, 8'h00, 16'h0);
        chk("R1", "writes", wn - w0, 1);
        chk("R1", "addr", wa[w0], 16'h01FF);
        chk("R1", "data", wd[w0], 8'hA5);
        chk("R1", "sp", sp, 8'hFE);
        chk("R10", "cycles", cyc, 2);
    endtask

    task automatic t_push_word();
        run_cmd(3'd1, 16'h1234, 8'h00, 16'h0);
        chk("R2", "hi addr/data", {wa[w0], wd[w0]}, {16'h01FE, 8'h12});
        chk("R2", "lo addr/data", {wa[w0+8'd1], wd[w0+8'd1]}, {16'h01FD, 8'h34});
        chk("R2", "sp", sp, 8'hFC);
        chk("R10", "cycles", cyc, 3);
    endtask

    task automatic t_pop_word();
        run_cmd(3'd3, 16'h0, 8'h00, 16'h0);
        chk("R4", "read order", {ra[r0], ra[r0+8'd1]}, {16'h01FD, 16'h01FE});
        chk("R4", "result", res_word, 16'h1234);
        chk("R4", "sp", sp, 8'hFE);
        chk("R4", "no underflow", underflow, 0);
    endtask

    task automatic t_pop_byte();
        run_cmd(3'd2, 16'h0, 8'h00, 16'h0);
        chk("R3", "addr", ra[r0], 16'h01FF);
        chk("R3", "result", res_word, 16'h00A5);
        chk("R3", "sp", sp, 8'hFF);
        chk("R10", "cycles", cyc, 2);
    endtask

    task automatic t_underflow_now();
        run_cmd(3'd2, 16'h0, 8'h00, 16'h0);
        chk("R5", "underflow", underflow, 1);
        chk("R5", "reads", rn - r0, 0);
        chk("R5", "sp", sp, 8'hFF);
        chk("R5", "cycles", cyc, 2);
    endtask

    task automatic t_context();
        run_cmd(3'd4, 16'hBEEF, 8'h5A, 16'h0);
        chk("R6", "w0", {wa[w0], wd[w0]}, {16'h01FF, 8'hBE});
        chk("R6", "w1", {wa[w0+8'd1], wd[w0+8'd1]}, {16'h01FE, 8'hEF});
        chk("R6", "w2", {wa[w0+8'd2], wd[w0+8'd2]}, {16'h01FD, 8'h5A});
        chk("R6", "sp", sp, 8'hFC);
        chk("R10", "cycles", cyc, 4);
    endtask

    task automatic t_ret_int();
        run_cmd(3'd5, 16'h0, 8'h00, 16'h0);
        chk("R7", "read order", {ra[r0], ra[r0+8'd1], ra[r0+8'd2]},
            {16'h01FD, 16'h01FE, 16'h01FF});
        chk("R7", "status", res_status, 8'h5A);
        chk("R7", "word", res_word, 16'hBEEF);
        chk("R7", "sp", sp, 8'hFF);
    endtask

    task automatic t_call_ret(input logic [15:0] ret_pc, input logic [15:0] tgt,
                              input logic [15:0] exp_ret);
        run_cmd(3'd7, ret_pc, 8'h00, tgt);
        chk("R9", "target", res_word, tgt);
        chk("R9", "hi first", {wa[w0], wd[w0]}, {16'h01FF, ret_pc[15:8]});
        chk("R9", "sp", sp, 8'hFD);
        run_cmd(3'd6, 16'h0, 8'h00, 16'h0);
        chk("R8", "return", res_word, exp_ret);
        chk("R8", "sp", sp, 8'hFF);
    endtask

    // A pop held on the command port during a busy push must not run.
    task automatic t_busy_ignore();
        @(negedge clk);
        w0 = wn; r0 = rn;
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_word = 16'h0077;
        @(posedge clk); #1;
        cmd_op = 3'd2;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 50) begin
            @(posedge clk); #1;
            cyc++;
        end
        repeat (4) @(posedge clk);
        #1;
        chk("R10", "writes", wn - w0, 1);
        chk("R10", "reads", rn - r0, 0);
        chk("R10", "sp", sp, 8'hFE);
        chk("R10", "idle", busy, 0);
    endtask

    task automatic t_underflow_partial();
        run_cmd(3'd3, 16'h0, 8'h00, 16'h0);
        chk("R5", "partial underflow", underflow, 1);
        chk("R5", "partial reads", rn - r0, 1);
        chk("R5", "partial sp", sp, 8'hFF);
        chk("R5", "partial low byte", res_word, 16'h0077);
        chk("R5", "partial cycles", cyc, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_push_byte();
        t_push_word();
        t_pop_word();
        t_pop_byte();
        t_underflow_now();
        t_context();
        t_ret_int();
        t_call_ret(16'h1233, 16'h4000, 16'h1234);
        t_call_ret(16'hFFFF, 16'h8000, 16'h0000);
        t_busy_ignore();
        t_underflow_partial();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule